// File: doc/BRIEF.md
# Shared-Line Serial Transmitter

This block sends bytes as asynchronous serial characters on a transmit wire that several devices share on the way back to one host. Each character is a low start bit, eight data bits with the least significant bit first, and one high stop bit. Every bit lasts a number of clock cycles set by a divider input. Bytes enter over a valid/ready stream. A flag sent with each byte marks the end of a message.

The pin is driven only inside a drive window. The window opens when the first byte of a message is accepted. It closes once the stop bit of the byte marked as message end has run its full length. Between messages the pin is released, so another device can use the wire. When both device-select mask inputs are zero, the pin is push-pull for the whole window. When either mask is nonzero, the pin is open-drain: it pulls low for low bits and releases for high bits, and an external pull-up supplies the high level. The data and output-enable outputs are separate, so the pad can tristate.

Back-pressure rule: a byte is taken on a rising clock edge where `s_valid` and `s_ready` are both high. `s_ready` stays low from that edge until the stop bit of that character has ended. The source must hold `s_data` and `s_last` stable while `s_valid` is high and `s_ready` is low.

Top module: `shared_line_tx`

## Requirements
- R1: A character is a start bit (0), then s_data[0] through s_data[7], then a stop bit (1). Each bit lasts clks_per_bit cycles, with 0 treated as 1. The start bit appears in the cycle after acceptance, and no extra high period comes before it.
- R2: s_ready falls in the cycle after a byte is accepted. It stays low until the stop bit has lasted its full length, then returns high in the next cycle.
- R3: When the drive mode is push-pull, tx_oe is 1 for the whole drive window and tx_out equals the line bit. Between two characters of the same message, the line is held driven high.
- R4: When the drive mode is open-drain, tx_oe is 1 only while the line bit is 0, and tx_out is 0 whenever tx_oe is 1. With a pull-up, the resulting line level equals the line bit.
- R5: Outside the drive window, tx_oe is 0.
- R6: A byte with s_last=1 closes the window in the cycle after its stop bit ends, so the stop bit is never cut short. A byte with s_last=0 keeps the window open after its stop bit.
- R7: The drive mode is open-drain when either sel_mask_a or sel_mask_b is nonzero, and push-pull otherwise. It is sampled only when a byte opens a closed window. Mask changes while the window is open have no effect until the next window opens.
- R8: clks_per_bit is sampled when a byte is accepted. Changes to it during a character have no effect on that character's timing.
- R9: After reset, s_ready is 1 and tx_oe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clks_per_bit | input | DIV_W | Clock cycles per bit; 0 is treated as 1 |
| sel_mask_a | input | MASK_W | First device-select mask; nonzero selects open-drain |
| sel_mask_b | input | MASK_W | Second device-select mask; nonzero selects open-drain |
| s_valid | input | 1 | Byte offered |
| s_ready | output | 1 | Transmitter can take a byte |
| s_data | input | DATA_W | Byte to send |
| s_last | input | 1 | Byte ends the message |
| tx_out | output | 1 | Pin data value |
| tx_oe | output | 1 | Pin output enable |

## Verification
A wrong bit index or a shifted register shows up as a wrong line level at the middle of the affected bit. That is within one bit time of the fault. A miscounted baud divider moves later bits away from their mid-bit sample points, and the fault becomes visible a few bits into the character. A drive window or drive mode held in the wrong state shows up at the enable pin. It appears either at the first high bit of a message, or in the cycle after the stop bit of a message-end byte, when the pin should have been released.

// File: rtl/slt_pkg.sv
package slt_pkg;
  typedef enum logic {
    DRV_PUSH_PULL  = 1'b0,
    DRV_OPEN_DRAIN = 1'b1
  } drive_mode_e;

  // start bit + stop bit added to the payload
  localparam int FRAME_OVERHEAD = 2;
endpackage

// File: rtl/slt_baud_timer.sv
module slt_baud_timer #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DIV_W-1:0] div_in,
  input  logic             run,
  output logic             tick
);
  logic [DIV_W-1:0] reload_q;
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] reload_d;

  always_comb begin
    reload_d = (div_in == '0) ? '0 : div_in - 1'b1;
  end

  assign tick = run && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reload_q <= '0;
      cnt_q    <= '0;
    end else if (load) begin
      reload_q <= reload_d;
      cnt_q    <= reload_d;
    end else if (tick) begin
      cnt_q <= reload_q;
    end else if (run) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/slt_frame_shifter.sv
module slt_frame_shifter
  import slt_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] data_in,
  input  logic              tick,
  output logic              busy,
  output logic              line_bit,
  output logic              done
);
  localparam int FRAME_W = DATA_W + FRAME_OVERHEAD;
  localparam int IDX_W   = $clog2(FRAME_W + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_W - 1);

  logic [FRAME_W-1:0] shreg_q;
  logic [IDX_W-1:0]   idx_q;
  logic               busy_q;

  assign busy     = busy_q;
  assign line_bit = busy_q ? shreg_q[0] : 1'b1;
  assign done     = busy_q && tick && (idx_q == LAST_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg_q <= '1;
      idx_q   <= '0;
      busy_q  <= 1'b0;
    end else if (load) begin
      shreg_q <= {1'b1, data_in, 1'b0};
      idx_q   <= '0;
      busy_q  <= 1'b1;
    end else if (done) begin
      shreg_q <= '1;
      idx_q   <= '0;
      busy_q  <= 1'b0;
    end else if (busy_q && tick) begin
      shreg_q <= {1'b1, shreg_q[FRAME_W-1:1]};
      idx_q   <= idx_q + 1'b1;
    end
  end
endmodule

// File: rtl/slt_drive_ctrl.sv
module slt_drive_ctrl
  import slt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        accept,
  input  logic        last_in,
  input  logic        char_done,
  input  drive_mode_e mode_req,
  input  logic        line_bit,
  output logic        tx_out,
  output logic        tx_oe,
  output drive_mode_e mode
);
  logic        win_q;
  logic        last_q;
  drive_mode_e mode_q;

  assign mode = mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_q  <= 1'b0;
      last_q <= 1'b0;
      mode_q <= DRV_PUSH_PULL;
    end else begin
      if (accept) begin
        win_q  <= 1'b1;
        last_q <= last_in;
        if (!win_q) mode_q <= mode_req;
      end else if (char_done && last_q) begin
        win_q <= 1'b0;
      end
    end
  end

  always_comb begin
    if (!win_q) begin
      tx_oe  = 1'b0;
      tx_out = 1'b1;
    end else if (mode_q == DRV_OPEN_DRAIN) begin
      tx_oe  = ~line_bit;
      tx_out = 1'b0;
    end else begin
      tx_oe  = 1'b1;
      tx_out = line_bit;
    end
  end
endmodule

// File: rtl/shared_line_tx.sv
module shared_line_tx
  import slt_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 16,
  parameter int MASK_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  clks_per_bit,
  input  logic [MASK_W-1:0] sel_mask_a,
  input  logic [MASK_W-1:0] sel_mask_b,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  input  logic              s_last,
  output logic              tx_out,
  output logic              tx_oe
);
  logic        busy;
  logic        tick;
  logic        line_bit;
  logic        char_done;
  logic        accept;
  drive_mode_e mode_req;
  drive_mode_e od_mode;

  assign s_ready  = ~busy;
  assign accept   = s_valid && s_ready;
  assign mode_req = ((|sel_mask_a) || (|sel_mask_b)) ? DRV_OPEN_DRAIN : DRV_PUSH_PULL;

  slt_baud_timer #(.DIV_W(DIV_W)) u_baud (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (accept),
    .div_in (clks_per_bit),
    .run    (busy),
    .tick   (tick)
  );

  slt_frame_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .data_in  (s_data),
    .tick     (tick),
    .busy     (busy),
    .line_bit (line_bit),
    .done     (char_done)
  );

  slt_drive_ctrl u_drive (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .last_in   (s_last),
    .char_done (char_done),
    .mode_req  (mode_req),
    .line_bit  (line_bit),
    .tx_out    (tx_out),
    .tx_oe     (tx_oe),
    .mode      (od_mode)
  );
endmodule

// File: rtl/shared_line_tx_chk.sv
module shared_line_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic s_valid,
  input logic s_ready,
  input logic tx_out,
  input logic tx_oe,
  input logic od_mode
);
  // R2: ready drops right after a byte is taken
  p_ready_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> !s_ready);

  // R1: start bit is actively driven low in the cycle after acceptance
  p_start_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> (tx_oe && !tx_out));

  // R4: open-drain never drives high
  p_od_low_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    od_mode |-> (!tx_oe || !tx_out));

  // R3: push-pull drives for the whole character
  p_pp_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!od_mode && !s_ready) |-> tx_oe);

  // R7: mode cannot change during a character
  p_mode_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!s_ready && !$rose(!s_ready)) |-> $stable(od_mode));
endmodule

bind shared_line_tx shared_line_tx_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .s_valid (s_valid),
  .s_ready (s_ready),
  .tx_out  (tx_out),
  .tx_oe   (tx_oe),
  .od_mode (od_mode == slt_pkg::DRV_OPEN_DRAIN)
);

// File: tb/tb_shared_line_tx.sv
module tb_shared_line_tx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] clks_per_bit = 16'd2;
  logic [31:0] sel_mask_a = '0;
  logic [31:0] sel_mask_b = '0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [7:0]  s_data = '0;
  logic        s_last = 1'b0;
  logic        tx_out;
  logic        tx_oe;

  int checks = 0;
  int errors = 0;
  bit od_model = 1'b0;
  bit win_model = 1'b0;

  shared_line_tx dut (
    .clk(clk), .rst_n(rst_n), .clks_per_bit(clks_per_bit),
    .sel_mask_a(sel_mask_a), .sel_mask_b(sel_mask_b),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_last(s_last),
    .tx_out(tx_out), .tx_oe(tx_oe)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit frame_bit(input logic [7:0] d, input int k);
    if (k == 0) return 1'b0;
    if (k == 9) return 1'b1;
    return d[k-1];
  endfunction

  // expected {oe,out}; out compared only when driven
  function automatic logic [1:0] pin_exp(input bit od, input bit b);
    if (od) return b ? 2'b01 : 2'b10;
    return {1'b1, b};
  endfunction

  function automatic logic [1:0] pin_act();
    return {tx_oe, tx_oe ? tx_out : 1'b1};
  endfunction

  task automatic send(input logic [7:0] d, input bit last, input int n,
                      input bit chg_mask, input bit chg_div);
    int eff_n;
    eff_n = (n == 0) ? 1 : n;
    @(negedge clk);
    while (!s_ready) @(negedge clk);
    clks_per_bit = 16'(n);
    s_data = d;
    s_last = last;
    s_valid = 1'b1;
    if (!win_model) od_model = (sel_mask_a != 0) || (sel_mask_b != 0);
    @(posedge clk);
    @(negedge clk);
    s_valid = 1'b0;
    win_model = 1'b1;
    for (int j = 0; j < 10*eff_n; j++) begin
      if (j > 0) @(negedge clk);
      if (j == 1 && chg_mask) begin  // R7: ignored mid-window
        sel_mask_a = od_model ? 32'd0 : 32'h0000_0100;
        sel_mask_b = '0;
      end
      if (j == 1 && chg_div) clks_per_bit = 16'(eff_n + 3);  // R8: ignored
      if (j % eff_n == eff_n / 2) begin
        // R1 framing, R3/R4 pin drive per mode, R2 ready low
        check(od_model ? "R1/R4" : "R1/R3", pin_act(),
              pin_exp(od_model, frame_bit(d, j / eff_n)));
        check("R2", {1'b0, s_ready}, 2'b00);
      end
    end
    @(negedge clk);
    if (last) win_model = 1'b0;
    check("R2", {1'b0, s_ready}, 2'b01);
    // R6/R5: released after a message end; push-pull keeps driving high otherwise
    check(last ? "R6/R5" : "R6/R3", {tx_oe, 1'b0},
          {(win_model && !od_model), 1'b0});
  endtask

  initial begin
    int cycles = 0;
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9", {s_ready, tx_oe}, 2'b10);
    check("R5", {1'b0, tx_oe}, 2'b00);

    // directed: push-pull message, fastest divider and zero divider
    send(8'hA5, 1'b0, 1, 1'b0, 1'b0);
    send(8'h00, 1'b0, 0, 1'b0, 1'b0);
    send(8'hFF, 1'b1, 3, 1'b0, 1'b0);
    // directed: open-drain via mask b only, mask flipped mid-window (R7)
    sel_mask_b = 32'h8000_0000;
    send(8'h3C, 1'b0, 4, 1'b1, 1'b1);
    send(8'hC3, 1'b1, 2, 1'b0, 1'b0);
    // new window now samples push-pull (mask a was cleared)
    sel_mask_a = '0; sel_mask_b = '0;
    send(8'h81, 1'b1, 5, 1'b1, 1'b0);

    // constrained random messages
    for (int m = 0; m < 25; m++) begin
      int len;
      len = 1 + ($urandom % 4);
      sel_mask_a = ($urandom % 2) ? 32'(1 << ($urandom % 32)) : 32'd0;
      sel_mask_b = ($urandom % 3 == 0) ? $urandom : 32'd0;
      for (int b = 0; b < len; b++) begin
        send(8'($urandom), (b == len - 1), 1 + ($urandom % 8),
             ($urandom % 2), ($urandom % 2));
        repeat ($urandom % 3) @(negedge clk);
        if (!win_model) check("R5", {1'b0, tx_oe}, 2'b00);
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule